// File: doc/BRIEF.md
# Binary to BCD Converter by Per-Digit Weighted Sums

This block turns a 16-bit unsigned binary value into five packed BCD digits. It does not shift and correct bit by bit. Each decimal position instead forms its own small binary sum of the input bits. The weight that bit i gets in position j is the j-th decimal digit of 2^i, and a bit whose weight is zero is left out. A chain of decimal digit adders then resolves these five position sums from the units upward. Each stage keeps its sum modulo ten and hands the quotient by ten to the next position as a carry, and that carry can be larger than one.

Each position sum is built from two balanced binary sub-sums over disjoint sets of input bits, which a final binary adder combines. The inputs go to the two sets in ascending weight order, each one to whichever set currently holds fewer members. For the units position, bit 0 bypasses the arithmetic and drives the least significant output bit directly. All other units weights are even, so that sum is formed at half weight and then shifted left.

The input is registered on the rising clock edge, and the conversion of the registered value appears at the output in the same cycle, so the output changes one edge after the input. An active-low asynchronous reset clears the input register.

Top module: `bin2bcd_ws`

## Requirements
- R1: Exactly one rising edge after bin_i is sampled, bcd_o holds its decimal value. Digit k sits in bits [4k+3:4k], with k=0 the units digit.
- R2: Every 4-bit digit of bcd_o is in the range 0 to 9.
- R3: The ten-thousands digit (bits [19:16]) never exceeds 6, and the last digit stage produces no carry out.
- R4: Bit 0 of bcd_o equals bit 0 of the value sampled at the previous rising edge.
- R5: While rst_ni is low, bcd_o is zero, and this takes effect without waiting for a clock edge.
- R6: The result is correct when the units position sum reaches its maximum of 75, so that a carry greater than one enters the tens position (for example 0xFFFF gives 65535).
- R7: The boundary inputs 0, 65535 and every power of two convert correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bin_i | input | 16 | Unsigned binary value |
| bcd_o | output | 20 | Five packed BCD digits, units in bits [3:0] |

## Verification
The bench sweeps every one of the 65536 input values in ascending order and compares each result with a decimal split computed by division. This catches any wrong weight, any lost term and any mis-sized carry in the digit chain. The all-ones and near-all-ones inputs drive the units sum to its peak, where a carry of seven enters the tens stage. Single-bit inputs give each weight an isolated check. Reset is applied at power-up and again between clock edges after a nonzero result, which separates an asynchronous clear from a synchronous one.

// File: rtl/bin2bcd_ws_pkg.sv
package bin2bcd_ws_pkg;

  function automatic int pow10(input int j);
    int r;
    r = 1;
    for (int k = 0; k < j; k++) r = r * 10;
    return r;
  endfunction

  // decimal digit j of 2^i
  function automatic int dig_w(input int i, input int j);
    return ((1 << i) / pow10(j)) % 10;
  endfunction

  // weight used in the sum; halved form drops bit 0 and divides by two
  function automatic int eff_w(input int i, input int j, input bit halve);
    if (halve) return (i == 0) ? 0 : dig_w(i, j) / 2;
    return dig_w(i, j);
  endfunction

  // balanced split: ascending weight, ties by index, alternate A/B
  function automatic bit in_set_a(input int i, input int j, input bit halve, input int bin_w);
    int w, wk, rank;
    w = eff_w(i, j, halve);
    if (w == 0) return 1'b0;
    rank = 0;
    for (int k = 0; k < bin_w; k++) begin
      wk = eff_w(k, j, halve);
      if (wk != 0 && (wk < w || (wk == w && k < i))) rank++;
    end
    return (rank % 2) == 0;
  endfunction

  function automatic int top_max(input int bin_w, input int ndig);
    return ((1 << bin_w) - 1) / pow10(ndig - 1);
  endfunction

endpackage

// File: rtl/ws_digit_sum.sv
module ws_digit_sum
  import bin2bcd_ws_pkg::*;
#(
  parameter int BIN_W = 16,
  parameter int DIG   = 0,
  parameter int SUM_W = 8,
  parameter bit HALVE = 1'b0
) (
  input  logic [BIN_W-1:0] bin_i,
  output logic [SUM_W-1:0] sum_o
);

  logic [SUM_W-1:0] term_a [BIN_W];
  logic [SUM_W-1:0] term_b [BIN_W];
  logic [SUM_W-1:0] sum_a, sum_b, total;

  for (genvar i = 0; i < BIN_W; i++) begin : g_term
    localparam int W    = eff_w(i, DIG, HALVE);
    localparam bit IN_A = in_set_a(i, DIG, HALVE, BIN_W);
    localparam bit IN_B = (W != 0) && !IN_A;
    assign term_a[i] = (IN_A && bin_i[i]) ? SUM_W'(W) : '0;
    assign term_b[i] = (IN_B && bin_i[i]) ? SUM_W'(W) : '0;
  end

  always_comb begin
    sum_a = '0;
    sum_b = '0;
    for (int k = 0; k < BIN_W; k++) begin
      sum_a = sum_a + term_a[k];
      sum_b = sum_b + term_b[k];
    end
    total = sum_a + sum_b;
  end

  if (HALVE) begin : g_half
    assign sum_o = {total[SUM_W-2:0], bin_i[0]};
  end else begin : g_full
    assign sum_o = total;
  end

endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add #(
  parameter int SUM_W = 8,
  parameter int CAR_W = 4
) (
  input  logic [SUM_W-1:0] sum_i,
  input  logic [CAR_W-1:0] carry_i,
  output logic [3:0]       digit_o,
  output logic [CAR_W-1:0] carry_o
);

  logic [SUM_W-1:0] total;

  always_comb begin
    total   = sum_i + SUM_W'(carry_i);
    digit_o = 4'(total % SUM_W'(10));
    carry_o = CAR_W'(total / SUM_W'(10));
  end

endmodule

// File: rtl/bin2bcd_ws.sv
module bin2bcd_ws
  import bin2bcd_ws_pkg::*;
#(
  parameter int BIN_W = 16,
  parameter int NDIG  = 5,
  parameter int SUM_W = 8,
  parameter int CAR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BIN_W-1:0]  bin_i,
  output logic [4*NDIG-1:0] bcd_o
);

  localparam int TOP_MAX = top_max(BIN_W, NDIG);

  logic [BIN_W-1:0] bin_q;
  logic             seen_q;
  logic [SUM_W-1:0] dsum  [NDIG];
  logic [3:0]       digit [NDIG];
  logic [CAR_W-1:0] carry [NDIG+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      bin_q  <= bin_i;
      seen_q <= 1'b1;
    end
  end

  assign carry[0] = '0;

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    ws_digit_sum #(
      .BIN_W(BIN_W), .DIG(j), .SUM_W(SUM_W), .HALVE(j == 0)
    ) u_sum (
      .bin_i(bin_q),
      .sum_o(dsum[j])
    );

    bcd_digit_add #(.SUM_W(SUM_W), .CAR_W(CAR_W)) u_add (
      .sum_i  (dsum[j]),
      .carry_i(carry[j]),
      .digit_o(digit[j]),
      .carry_o(carry[j+1])
    );

    assign bcd_o[4*j +: 4] = digit[j];

    // R2
    nibble_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      digit[j] <= 4'd9);
  end

  // R3
  top_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_o[4*NDIG-1 -: 4] <= 4'(TOP_MAX));

  // R3
  no_carry_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry[NDIG] == '0);

  // R4
  units_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> bcd_o[0] == $past(bin_i[0]));

  // R5
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> bcd_o == '0);

endmodule

// File: tb/bin2bcd_ws_test.sv
module bin2bcd_ws_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bin_i = 16'hFFFF;
  logic [19:0] bcd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bin2bcd_ws uut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bin_i (bin_i),
    .bcd_o (bcd_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [19:0] exp_bcd(input int v);
    logic [19:0] r;
    int d;
    r = '0;
    d = 1;
    for (int k = 0; k < 5; k++) begin
      r[4*k +: 4] = 4'((v / d) % 10);
      d = d * 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input int v, input string req);
    @(negedge clk_i);
    bin_i = 16'(v);
    @(posedge clk_i);
    #1;
    check(req, bcd_o, exp_bcd(v));
  endtask

  initial begin
    #20;
    check("R5 reset", bcd_o, 20'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 boundaries and single bits
    apply(0, "R7 zero");
    apply(65535, "R7 max");
    for (int i = 0; i < 16; i++) apply(1 << i, "R7 power of two");

    // R6 peak units sum
    apply(16'hFFFF, "R6 peak");
    apply(16'hFFFE, "R6 peak");
    apply(16'h7FFF, "R6 peak");

    // R5 asynchronous clear between edges
    apply(12345, "R1 before reset");
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0;
    #1;
    check("R5 async", bcd_o, 20'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1..R4 exhaustive sweep
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk_i);
      bin_i = 16'(v);
      @(posedge clk_i);
      #1;
      check("R1 value", bcd_o, exp_bcd(v));
      checks++;
      if (bcd_o[3:0] > 9 || bcd_o[7:4] > 9 || bcd_o[11:8] > 9 ||
          bcd_o[15:12] > 9 || bcd_o[19:16] > 9) begin
        errors++;
        $display("FAIL R2: actual %h expected all digits <= 9", bcd_o);
      end
      checks++;
      if (bcd_o[19:16] > 6) begin
        errors++;
        $display("FAIL R3: actual %0d expected <= 6", bcd_o[19:16]);
      end
      checks++;
      if (bcd_o[0] !== bin_i[0]) begin
        errors++;
        $display("FAIL R4: actual %b expected %b", bcd_o[0], bin_i[0]);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule